// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block runs one complete clause-22 station management transaction on the MDC/MDIO pair each time software writes a 32-bit command word. The command word carries every field of the frame. The engine first sends a preamble of 32 ones and then shifts the command word out, most significant bit first. For a read it releases the data line from the turnaround onward and shifts the bits it samples into the low 16 bits of the same command register. Software polls an idle flag to learn when the transaction has ended, then reads the command register back to collect the result.

MDC is derived from the system clock. A 2-bit select picks a divide ratio of 8, 16, 32 or 64, and the select is latched when a frame starts. A port-enable input gates the engine: while it is low, command writes are dropped and MDC and MDIO stay quiet. The semantics of the PHY registers are outside this block.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset, idle_o is 1, mdc_o is 0, mdio_oe_o is 0 and cmd_o is 0.
- R2: A cycle with wr_en_i=1, mgmt_en_i=1 and idle_o=1 accepts wr_data_i into the command register. idle_o is 0 from the next cycle and returns to 1 exactly 64*D clock cycles after the accepting edge, where D is the divide ratio.
- R3: clk_div_i values 0, 1, 2 and 3 select D = 8, 16, 32 and 64. Within each bit time, MDC is low for the first D/2 cycles and high for the last D/2 cycles.
- R4: The command word layout is [31:30] start code, [29:28] opcode, [27:23] PHY address, [22:18] register address, [17:16] turnaround, [15:0] data. On each MDC rising edge of the frame, MDIO carries one frame bit: bits 0..31 are 1, and bit 32+k is command bit 31-k.
- R5: An opcode of 2'b10 marks a read. For a read, mdio_oe_o is 0 from frame bit 46 (the first turnaround bit) through bit 63, and is 1 for bits 0..45.
- R6: For a read, mdio_i is sampled at each MDC rising edge of frame bits 48..63 and shifted MSB first into cmd_o[15:0]. Bit 48 ends up in cmd_o[15]. cmd_o[31:16] stays as written.
- R7: For any other opcode, all 64 frame bits are driven with mdio_oe_o=1, and cmd_o keeps the written value.
- R8: A command write made while idle_o=0 is ignored. The frame in progress and cmd_o are unchanged.
- R9: With mgmt_en_i=0 a command write is ignored: idle_o stays 1, mdc_o stays 0 and cmd_o is unchanged.
- R10: While idle_o=1, mdc_o is 0, mdio_oe_o is 0 and mdio_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mgmt_en_i | input | 1 | Management port enable |
| clk_div_i | input | 2 | MDC divide select (8/16/32/64) |
| wr_en_i | input | 1 | Command register write strobe |
| wr_data_i | input | 32 | Command word to write |
| cmd_o | output | 32 | Command register readback, read data in [15:0] |
| idle_o | output | 1 | High when no frame is in progress |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest case to reach from the ports is the alignment of read sampling with the MDC rising edge. A PHY model must present each data bit for exactly the right bit time, or an off-by-one shift goes unseen. The bench counts MDC rising edges and drives mdio_i from that count, using a pattern with distinct neighbouring bits, so a sample taken one edge early or late changes the value read back. A second command word is written in the middle of a frame, and that frame's captured bit stream and readback are then compared with the first command's values, to show that the second write left the frame alone.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN   = 32;
  localparam int CMD_W     = 32;
  localparam int DATA_W    = 16;
  localparam int DIV_LOG2  = 3;
  localparam int SEL_W     = 2;
  localparam int FRAME_LEN = PRE_LEN + CMD_W;
  localparam int TA_BIT    = FRAME_LEN - DATA_W - 2;
  localparam int DATA_BIT  = FRAME_LEN - DATA_W;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef struct packed {
    logic [1:0]        start;
    logic [1:0]        op;
    logic [4:0]        phy;
    logic [4:0]        regad;
    logic [1:0]        ta;
    logic [DATA_W-1:0] data;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
  import mdio_pkg::*;
#(
  parameter int DIV_MIN_LOG2 = DIV_LOG2,
  parameter int SW           = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [SW-1:0] sel_i,
  output logic          mdc_o,
  output logic          rise_o,
  output logic          bit_end_o
);
  localparam int DIV_MIN = 1 << DIV_MIN_LOG2;
  localparam int CNT_W   = DIV_MIN_LOG2 + (1 << SW) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_last, half_last;

  assign cnt_last  = CNT_W'((DIV_MIN << sel_i) - 1);
  assign half_last = CNT_W'(((DIV_MIN / 2) << sel_i) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!run_i || cnt_q == cnt_last) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end

  assign mdc_o     = run_i && (cnt_q > half_last);
  assign rise_o    = run_i && (cnt_q == half_last);
  assign bit_end_o = run_i && (cnt_q == cnt_last);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PL = PRE_LEN,
  parameter int CW = CMD_W,
  parameter int DW = DATA_W,
  parameter int SW = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic [SW-1:0] sel_i,
  input  logic          rise_i,
  input  logic          bit_end_i,
  input  logic          mdio_i,
  output logic          busy_o,
  output logic [SW-1:0] sel_o,
  output logic [CW-1:0] cmd_o,
  output logic          mdio_o,
  output logic          mdio_oe_o
);
  localparam int FL    = PL + CW;
  localparam int IDX_W = $clog2(FL);
  localparam int POS_W = $clog2(CW);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FL - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(FL - DW - 2);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(FL - DW);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q, off;
  logic [POS_W-1:0] pos;
  logic [CW-1:0]    cmd_q;
  logic [SW-1:0]    sel_q;
  logic             is_read, frame_bit;

  assign is_read = (cmd_q[CW-3 -: 2] == OP_READ);
  assign off     = idx_q - IDX_W'(PL);
  assign pos     = POS_W'(CW - 1) - off[POS_W-1:0];
  assign frame_bit = (idx_q < IDX_W'(PL)) ? 1'b1 : cmd_q[pos];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cmd_q  <= '0;
      sel_q  <= '0;
    end else if (accept_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      cmd_q  <= wr_data_i;
      sel_q  <= sel_i;
    end else if (busy_q) begin
      if (rise_i && is_read && idx_q >= DAT_IDX)
        cmd_q[DW-1:0] <= {cmd_q[DW-2:0], mdio_i};
      if (bit_end_i) begin
        if (idx_q == LAST_IDX) busy_q <= 1'b0;
        else                   idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o    = busy_q;
  assign sel_o     = sel_q;
  assign cmd_o     = cmd_q;
  assign mdio_o    = busy_q ? frame_bit : 1'b1;
  assign mdio_oe_o = busy_q && !(is_read && idx_q >= TA_IDX);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mgmt_en_i,
  input  logic [SEL_W-1:0] clk_div_i,
  input  logic             wr_en_i,
  input  logic [CMD_W-1:0] wr_data_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             idle_o,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  input  logic             mdio_i
);
  logic busy, accept, rise, bit_end;
  logic [SEL_W-1:0] sel_run;

  assign accept = wr_en_i && mgmt_en_i && !busy;
  assign idle_o = !busy;

  mdio_mdc_gen #(.DIV_MIN_LOG2(DIV_LOG2), .SW(SEL_W)) u_mdc (
    .clk_i, .rst_ni, .run_i(busy), .sel_i(sel_run),
    .mdc_o, .rise_o(rise), .bit_end_o(bit_end)
  );

  mdio_frame_seq #(.PL(PRE_LEN), .CW(CMD_W), .DW(DATA_W), .SW(SEL_W)) u_seq (
    .clk_i, .rst_ni, .accept_i(accept), .wr_data_i, .sel_i(clk_div_i),
    .rise_i(rise), .bit_end_i(bit_end), .mdio_i,
    .busy_o(busy), .sel_o(sel_run), .cmd_o, .mdio_o, .mdio_oe_o
  );
endmodule

// File: rtl/mdio_frame_engine_chk.sv
module mdio_frame_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mgmt_en_i,
  input logic        wr_en_i,
  input logic [31:0] cmd_o,
  input logic        idle_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  // R2
  accept_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && mgmt_en_i && idle_o) |=> !idle_o);
  // R8
  busy_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !idle_o) |=> $stable(cmd_o[31:16]));
  // R9
  disabled_stays_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mgmt_en_i && idle_o) |=> idle_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (!mdc_o && !mdio_oe_o && mdio_o));
  // R4
  preamble_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(idle_o) |-> (mdio_o && mdio_oe_o && !mdc_o));
endmodule

bind mdio_frame_engine mdio_frame_engine_chk u_chk (
  .clk_i, .rst_ni, .mgmt_en_i, .wr_en_i, .cmd_o, .idle_o, .mdc_o, .mdio_o, .mdio_oe_o
);

// File: tb/mdio_frame_engine_test.sv
`timescale 1ns/1ps
module mdio_frame_engine_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic mgmt_en = 1'b1, wr_en = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] cmd;
  logic idle, mdc, mdio_o, mdio_oe, mdio_i;

  int n_tests = 0, n_fail = 0;
  int rcnt = 0;
  logic [15:0] phy_val = '0;
  logic [63:0] cap_bits, cap_oe;

  always #5 clk = ~clk;

  mdio_frame_engine uut (
    .clk_i(clk), .rst_ni, .mgmt_en_i(mgmt_en), .clk_div_i(div_sel),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .cmd_o(cmd), .idle_o(idle),
    .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: data bits 48..63 from phy_val MSB first, pull-up elsewhere
  assign mdio_i = (rcnt >= 48 && rcnt < 64) ? phy_val[63 - rcnt] : 1'b1;

  always @(posedge mdc) begin
    if (rcnt < 64) begin
      cap_bits[63 - rcnt] = mdio_o;
      cap_oe[63 - rcnt]   = mdio_oe;
    end
    rcnt = rcnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // {sel, cmd, phy data}
  localparam int NV = 6;
  localparam logic [49:0] VEC [NV] = '{
    {2'd0, 2'b01, 2'b10, 5'd3,  5'd2,  2'b10, 16'h0000, 16'hA5C3},
    {2'd0, 2'b01, 2'b01, 5'd1,  5'd4,  2'b10, 16'h1234, 16'h0000},
    {2'd1, 2'b01, 2'b10, 5'd31, 5'd31, 2'b10, 16'hFFFF, 16'h6A59},
    {2'd2, 2'b01, 2'b01, 5'd16, 5'd9,  2'b10, 16'hBEEF, 16'h0000},
    {2'd3, 2'b01, 2'b10, 5'd0,  5'd1,  2'b10, 16'h0000, 16'h8001},
    {2'd3, 2'b01, 2'b01, 5'd21, 5'd10, 2'b10, 16'h5AA5, 16'h0000}
  };

  task automatic start_frame(input logic [1:0] s, input logic [31:0] c);
    @(negedge clk);
    rcnt = 0; cap_bits = '0; cap_oe = '0;
    div_sel = s; wr_data = c; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_vec(input logic [1:0] s, input logic [31:0] c, input logic [15:0] pv);
    int n;
    int d;
    logic rd;
    logic [63:0] exp_bits, exp_oe, mask;
    logic [31:0] exp_cmd;
    d = 8 << s;
    rd = (c[29:28] == 2'b10);
    phy_val = pv;
    @(negedge clk);
    rcnt = 0; cap_bits = '0; cap_oe = '0;
    div_sel = s; wr_data = c; wr_en = 1'b1;
    @(posedge clk);
    n = 0;
    #1 wr_en = 1'b0;
    chk(!idle, "R2 idle low after accept", {63'd0, idle}, 64'd0);
    while (!idle && n < 5000) begin
      @(posedge clk); n++; #1;
    end
    chk(n == 64 * d, $sformatf("R2/R3 duration sel=%0d", s), n, 64 * d);
    chk(rcnt == 64, "R3 MDC rising edges per frame", rcnt, 64);
    exp_bits = {32'hFFFF_FFFF, c};
    mask = rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : '1;
    exp_oe = mask;
    chk((cap_bits & mask) == (exp_bits & mask), "R4 frame bits", cap_bits, exp_bits);
    chk(cap_oe == exp_oe, rd ? "R5 read release" : "R7 write drive", cap_oe, exp_oe);
    exp_cmd = rd ? {c[31:16], pv} : c;
    chk(cmd == exp_cmd, rd ? "R6 read data" : "R7 cmd kept", cmd, exp_cmd);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] first_cmd;
    logic seen_mdc;
    repeat (3) @(negedge clk);
    chk(idle && !mdc && !mdio_oe && cmd == 0, "R1 reset state", {cmd, 29'd0, idle, mdc, mdio_oe}, {32'd0, 32'd4});
    rst_ni = 1'b1;
    @(negedge clk);
    chk(mdio_o && !mdio_oe && !mdc, "R10 idle quiet", {61'd0, mdio_o, mdio_oe, mdc}, 64'd4);

    for (int i = 0; i < NV; i++)
      run_vec(VEC[i][49:48], VEC[i][47:16], VEC[i][15:0]);

    // R8: write during a busy frame is ignored
    first_cmd = {2'b01, 2'b01, 5'd7, 5'd3, 2'b10, 16'hC0DE};
    start_frame(2'd0, first_cmd);
    repeat (100) @(negedge clk);
    wr_data = 32'h6BFF_1111; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    while (!idle) @(negedge clk);
    chk(cmd == first_cmd, "R8 cmd unchanged", cmd, first_cmd);
    chk(cap_bits == {32'hFFFF_FFFF, first_cmd}, "R8 frame unchanged", cap_bits, {32'hFFFF_FFFF, first_cmd});

    // R9: port disabled
    mgmt_en = 1'b0;
    seen_mdc = 1'b0;
    @(negedge clk);
    wr_data = 32'h6000_0000; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (mdc || !idle) seen_mdc = 1'b1;
    end
    chk(!seen_mdc, "R9 no frame while disabled", {63'd0, seen_mdc}, 64'd0);
    chk(cmd == first_cmd, "R9 cmd unchanged", cmd, first_cmd);
    chk(idle && !mdio_oe && mdio_o, "R10 idle after disabled write", {61'd0, idle, mdio_oe, mdio_o}, 64'd5);
    mgmt_en = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule